// File: doc/BRIEF.md
# Pre-decoder buffer fullness verifier

This block watches a compressed video stream as it passes into the input buffer of a decoder and checks, in real time, that a buffer of a given capacity would neither run dry nor spill. A per-cycle channel-active strobe stands for bits arriving at a fixed peak rate. A stream of per-picture coded sizes tells the block how many bits each picture takes out of the buffer.

The buffer starts empty. No picture is removed until the modelled fullness has reached a programmed initial level. At that point the first picture is taken out, and the block records how long the fill took. After that, one whole picture is removed on every frame tick, and frame ticks are a programmed number of cycles apart. The block reports the running fullness and its highest value. It raises sticky flags for underflow, overflow and a picture size that is missing when a removal is due.

Top module: `prebuf_verifier`

## Requirements
- R1: After synchronous reset, fullness, peak fullness and startup delay read 0, started is 0, all three error flags are 0, and size_ready is 0 provided the initial-fullness setting is nonzero.
- R2: In a cycle without a removal, fullness grows by cfg_rate when chan_active is 1 and stays unchanged when it is 0. The new value is visible after the next clock edge.
- R3: The first removal is offered (size_ready high) in the first cycle whose registered fullness is at least cfg_init_fill. From the following cycle, started is 1 and stays 1 until reset.
- R4: startup_ticks counts the cycles from the first cycle with chan_active high up to, but not including, the start cycle. After the start it is frozen.
- R5: After the start cycle, a removal is offered every cfg_frame_period cycles (period of at least 1), counted from the start cycle.
- R6: When a removal and an arrival fall in the same cycle, the next fullness is fullness + arrival - size.
- R7: If fullness plus the same-cycle arrival is smaller than the size being removed, err_underflow is set and fullness becomes 0.
- R8: If the result would exceed cfg_capacity, err_overflow is set and fullness is held at cfg_capacity. Fullness never exceeds the capacity.
- R9: peak_fullness is the largest fullness value held since reset. It never decreases.
- R10: When size_ready is high and size_valid is low, err_missing is set and size_ready stays high until a size is accepted. The schedule of later frame ticks is not shifted by the stall.
- R11: The error flags are sticky until clr_err is high for a cycle. A new error in the same cycle as the clear leaves the flag set.
- R12: A size offered with size_valid while size_ready is low is not consumed and does not change fullness.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_err | input | 1 | Synchronous clear of the sticky error flags |
| cfg_rate | input | RATE_W | Bits delivered per active cycle |
| cfg_init_fill | input | FILL_W | Fullness that triggers the first removal |
| cfg_capacity | input | FILL_W | Buffer capacity in bits |
| cfg_frame_period | input | PER_W | Cycles between removals (at least 1) |
| chan_active | input | 1 | Channel delivers cfg_rate bits this cycle |
| size_valid | input | 1 | A picture size is offered |
| size_data | input | SIZE_W | Coded size of the offered picture in bits |
| size_ready | output | 1 | A removal is due; the offered size is taken |
| fullness | output | FILL_W | Current modelled buffer fullness |
| peak_fullness | output | FILL_W | Highest fullness since reset |
| startup_ticks | output | DLY_W | Cycles from first arrival to first removal |
| started | output | 1 | First removal has taken place |
| err_underflow | output | 1 | Sticky: a removal exceeded the available bits |
| err_overflow | output | 1 | Sticky: fullness exceeded capacity |
| err_missing | output | 1 | Sticky: no size was offered when a removal was due |

## Verification
The two functions that most often share a cycle are an arrival and a picture removal. The bench keeps chan_active high through frame ticks, with several sizes, so that the sum and the subtraction are resolved in the same edge. It compares the result against fullness + rate - size, or against the clamped value at the underflow and capacity limits. It also issues the error clear in cycles where a removal is stalled, and checks that the fresh missing-size event wins over the clear.

// File: rtl/prebuf_pkg.sv
package prebuf_pkg;
  // Events raised by the fullness arithmetic in one cycle.
  typedef struct packed {
    logic under;
    logic over;
  } fill_evt_t;
endpackage

// File: rtl/prebuf_frame_timer.sv
module prebuf_frame_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] cfg_period,
  input  logic             fill_reached,
  output logic             tick,
  output logic             started
);
  logic [PER_W-1:0] cnt_q;
  logic             started_q;

  // First tick comes from the fill threshold, later ones from the counter.
  assign tick    = started_q ? (cnt_q == '0) : fill_reached;
  assign started = started_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      cnt_q     <= '0;
    end else if (tick) begin
      started_q <= 1'b1;
      cnt_q     <= cfg_period - 1'b1;
    end else if (started_q) begin
      cnt_q     <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/prebuf_fill_engine.sv
module prebuf_fill_engine
  import prebuf_pkg::*;
#(
  parameter int FILL_W = 20,
  parameter int SIZE_W = 20,
  parameter int RATE_W = 12
) (
  input  logic [FILL_W-1:0] fill,
  input  logic              arrive,
  input  logic [RATE_W-1:0] rate,
  input  logic              take,
  input  logic [SIZE_W-1:0] size,
  input  logic [FILL_W-1:0] capacity,
  output logic [FILL_W-1:0] fill_next,
  output fill_evt_t         evt
);
  localparam int EXT_W = FILL_W + 2;

  logic [EXT_W-1:0] sum;
  logic [EXT_W-1:0] size_x;
  logic [EXT_W-1:0] after_take;

  always_comb begin
    sum        = EXT_W'(fill) + (arrive ? EXT_W'(rate) : '0);
    size_x     = EXT_W'(size);
    evt        = '0;
    after_take = sum;
    if (take) begin
      if (sum < size_x) begin
        evt.under  = 1'b1;
        after_take = '0;
      end else begin
        after_take = sum - size_x;
      end
    end
    if (after_take > EXT_W'(capacity)) begin
      evt.over  = 1'b1;
      fill_next = capacity;
    end else begin
      fill_next = after_take[FILL_W-1:0];
    end
  end
endmodule

// File: rtl/prebuf_startup_meter.sv
module prebuf_startup_meter #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_active,
  input  logic             started,
  input  logic             tick,
  output logic [DLY_W-1:0] delay
);
  logic             arrived_q;
  logic [DLY_W-1:0] delay_q;
  logic             count_en;

  assign count_en = !started && !tick && (arrived_q || chan_active);
  assign delay    = delay_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arrived_q <= 1'b0;
      delay_q   <= '0;
    end else begin
      if (chan_active) arrived_q <= 1'b1;
      if (count_en && (delay_q != '1)) delay_q <= delay_q + 1'b1;
    end
  end
endmodule

// File: rtl/prebuf_verifier.sv
module prebuf_verifier
  import prebuf_pkg::*;
#(
  parameter int FILL_W = 20,
  parameter int SIZE_W = 20,
  parameter int RATE_W = 12,
  parameter int PER_W  = 16,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_err,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic [FILL_W-1:0] cfg_init_fill,
  input  logic [FILL_W-1:0] cfg_capacity,
  input  logic [PER_W-1:0]  cfg_frame_period,
  input  logic              chan_active,
  input  logic              size_valid,
  input  logic [SIZE_W-1:0] size_data,
  output logic              size_ready,
  output logic [FILL_W-1:0] fullness,
  output logic [FILL_W-1:0] peak_fullness,
  output logic [DLY_W-1:0]  startup_ticks,
  output logic              started,
  output logic              err_underflow,
  output logic              err_overflow,
  output logic              err_missing
);
  logic [FILL_W-1:0] fill_q, peak_q, fill_nxt;
  logic              pend_q;
  logic              under_q, over_q, miss_q;
  logic              tick, take, miss_evt, fill_reached;
  fill_evt_t         evt;

  assign fill_reached = (fill_q >= cfg_init_fill);

  prebuf_frame_timer #(.PER_W(PER_W)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .cfg_period   (cfg_frame_period),
    .fill_reached (fill_reached),
    .tick         (tick),
    .started      (started)
  );

  prebuf_startup_meter #(.DLY_W(DLY_W)) u_meter (
    .clk         (clk),
    .rst         (rst),
    .chan_active (chan_active),
    .started     (started),
    .tick        (tick),
    .delay       (startup_ticks)
  );

  // A removal stays due across cycles without a size; ticks keep their pace.
  assign size_ready = pend_q | tick;
  assign take       = size_ready & size_valid;
  assign miss_evt   = size_ready & ~size_valid;

  prebuf_fill_engine #(
    .FILL_W (FILL_W),
    .SIZE_W (SIZE_W),
    .RATE_W (RATE_W)
  ) u_engine (
    .fill      (fill_q),
    .arrive    (chan_active),
    .rate      (cfg_rate),
    .take      (take),
    .size      (size_data),
    .capacity  (cfg_capacity),
    .fill_next (fill_nxt),
    .evt       (evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q  <= '0;
      peak_q  <= '0;
      pend_q  <= 1'b0;
      under_q <= 1'b0;
      over_q  <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      fill_q  <= fill_nxt;
      if (fill_nxt > peak_q) peak_q <= fill_nxt;
      pend_q  <= miss_evt;
      under_q <= (under_q & ~clr_err) | evt.under;
      over_q  <= (over_q  & ~clr_err) | evt.over;
      miss_q  <= (miss_q  & ~clr_err) | miss_evt;
    end
  end

  assign fullness      = fill_q;
  assign peak_fullness = peak_q;
  assign err_underflow = under_q;
  assign err_overflow  = over_q;
  assign err_missing   = miss_q;
endmodule

// File: rtl/prebuf_verifier_chk.sv
module prebuf_verifier_chk #(
  parameter int FILL_W = 20,
  parameter int DLY_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_err,
  input logic [FILL_W-1:0] cfg_capacity,
  input logic              chan_active,
  input logic              size_valid,
  input logic              size_ready,
  input logic [FILL_W-1:0] fullness,
  input logic [FILL_W-1:0] peak_fullness,
  input logic [DLY_W-1:0]  startup_ticks,
  input logic              started,
  input logic              err_underflow,
  input logic              err_missing
);
  p_idle_steady_r2: assert property (@(posedge clk) disable iff (rst)
    (!chan_active && !size_ready) |=> (fullness == $past(fullness)));

  p_start_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    started |=> started);

  p_delay_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    started |=> $stable(startup_ticks));

  p_within_capacity_r8: assert property (@(posedge clk) disable iff (rst)
    fullness <= cfg_capacity);

  p_peak_covers_r9: assert property (@(posedge clk) disable iff (rst)
    peak_fullness >= fullness);

  p_peak_monotone_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (peak_fullness >= $past(peak_fullness)));

  p_ready_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (size_ready && !size_valid) |=> size_ready);

  p_missing_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (size_ready && !size_valid) |=> err_missing);

  p_underflow_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (err_underflow && !clr_err) |=> err_underflow);

  p_unready_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    (!chan_active && !size_ready && size_valid) |=> $stable(fullness));
endmodule

bind prebuf_verifier prebuf_verifier_chk #(
  .FILL_W (FILL_W),
  .DLY_W  (DLY_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .clr_err       (clr_err),
  .cfg_capacity  (cfg_capacity),
  .chan_active   (chan_active),
  .size_valid    (size_valid),
  .size_ready    (size_ready),
  .fullness      (fullness),
  .peak_fullness (peak_fullness),
  .startup_ticks (startup_ticks),
  .started       (started),
  .err_underflow (err_underflow),
  .err_missing   (err_missing)
);

// File: tb/prebuf_verifier_test.sv
module prebuf_verifier_test;
  localparam int FILL_W = 20;
  localparam int SIZE_W = 20;
  localparam int RATE_W = 12;
  localparam int PER_W  = 16;
  localparam int DLY_W  = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst = 1'b1, clr_err = 1'b0;
  logic [RATE_W-1:0] cfg_rate = '0;
  logic [FILL_W-1:0] cfg_init_fill = '0, cfg_capacity = '0;
  logic [PER_W-1:0]  cfg_frame_period = '0;
  logic              chan_active = 1'b0, size_valid = 1'b0;
  logic [SIZE_W-1:0] size_data = '0;
  logic              size_ready, started, err_underflow, err_overflow, err_missing;
  logic [FILL_W-1:0] fullness, peak_fullness;
  logic [DLY_W-1:0]  startup_ticks;

  prebuf_verifier #(.FILL_W(FILL_W), .SIZE_W(SIZE_W), .RATE_W(RATE_W),
                    .PER_W(PER_W), .DLY_W(DLY_W)) uut (
    .clk(clk), .rst(rst), .clr_err(clr_err), .cfg_rate(cfg_rate),
    .cfg_init_fill(cfg_init_fill), .cfg_capacity(cfg_capacity),
    .cfg_frame_period(cfg_frame_period), .chan_active(chan_active),
    .size_valid(size_valid), .size_data(size_data), .size_ready(size_ready),
    .fullness(fullness), .peak_fullness(peak_fullness),
    .startup_ticks(startup_ticks), .started(started),
    .err_underflow(err_underflow), .err_overflow(err_overflow),
    .err_missing(err_missing));

  typedef struct {
    int fill; int peak; int dly;
    bit und; bit ovf; bit mis; bit sta; bit rdy;
    string tag;
  } exp_t;
  exp_t q[$];

  int n_checks = 0, n_errs = 0;
  int R, F, CAP, P;
  int m_fill, m_peak, m_cnt, m_dly;
  bit m_sta, m_pend, m_arr, m_und, m_ovf, m_mis;

  task automatic chk(string tag, string what, int got, int want);
    n_checks++;
    if (got != want) begin
      n_errs++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, want);
    end
  endtask

  // Monitor: compares the design state after each edge with the queued item.
  always @(negedge clk) begin : mon
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(e.tag, "fullness", int'(fullness), e.fill);
      chk("R9", "peak", int'(peak_fullness), e.peak);
      chk("R4", "startup", int'(startup_ticks), e.dly);
      chk("R7", "underflow flag", int'(err_underflow), int'(e.und));
      chk("R8", "overflow flag", int'(err_overflow), int'(e.ovf));
      chk("R10", "missing flag", int'(err_missing), int'(e.mis));
      chk("R3", "started", int'(started), int'(e.sta));
      chk("R5", "size_ready", int'(size_ready), int'(e.rdy));
    end
  end

  task automatic do_reset(int r, int f, int cap, int p);
    rst = 1'b1; chan_active = 1'b0; size_valid = 1'b0; clr_err = 1'b0;
    cfg_rate = RATE_W'(r); cfg_init_fill = FILL_W'(f);
    cfg_capacity = FILL_W'(cap); cfg_frame_period = PER_W'(p);
    R = r; F = f; CAP = cap; P = p;
    m_fill = 0; m_peak = 0; m_cnt = 0; m_dly = 0;
    m_sta = 0; m_pend = 0; m_arr = 0; m_und = 0; m_ovf = 0; m_mis = 0;
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk("R1", "fullness", int'(fullness), 0);
    chk("R1", "peak", int'(peak_fullness), 0);
    chk("R1", "startup", int'(startup_ticks), 0);
    chk("R1", "started", int'(started), 0);
    chk("R1", "flags", int'({err_underflow, err_overflow, err_missing}), 0);
    chk("R1", "size_ready", int'(size_ready), 0);
    rst = 1'b0;
  endtask

  // Driver: applies one cycle of stimulus and queues the expected outcome.
  task automatic cyc(bit act, bit vld, int sz, bit clr, string tag);
    bit tick, rdy, take, und, ovf, mis;
    int sum, nf;
    exp_t e;
    chan_active = act; size_valid = vld; size_data = SIZE_W'(sz); clr_err = clr;
    tick = m_sta ? (m_cnt == 0) : (m_fill >= F);
    rdy  = m_pend || tick;
    take = rdy && vld;
    sum  = m_fill + (act ? R : 0);
    und = 0; ovf = 0;
    nf  = sum;
    if (take) begin
      if (sum < sz) begin und = 1; nf = 0; end
      else nf = sum - sz;
    end
    if (nf > CAP) begin ovf = 1; nf = CAP; end
    mis = rdy && !vld;
    if (!m_sta && !tick && (m_arr || act)) m_dly++;
    if (act) m_arr = 1;
    if (tick) m_cnt = P - 1;
    else if (m_sta) m_cnt--;
    if (tick) m_sta = 1;
    m_pend = mis;
    m_fill = nf;
    if (nf > m_peak) m_peak = nf;
    m_und = (m_und && !clr) || und;
    m_ovf = (m_ovf && !clr) || ovf;
    m_mis = (m_mis && !clr) || mis;
    e.fill = m_fill; e.peak = m_peak; e.dly = m_dly;
    e.und = m_und; e.ovf = m_ovf; e.mis = m_mis; e.sta = m_sta;
    e.rdy = m_pend || (m_sta ? (m_cnt == 0) : (m_fill >= F));
    e.tag = tag;
    @(posedge clk);
    #1 q.push_back(e);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  initial begin : watchdog
    #(4 * 200000);
    n_checks++; n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    do_reset(10, 30, 100, 4);
    // R2: idle then filling, no removal yet
    for (int i = 0; i < 2; i++) cyc(0, 0, 0, 0, "R2");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, "R2");
    // R3 start with arrival and removal in the same cycle (R6)
    cyc(1, 1, 25, 0, "R6");
    chk("R4", "startup after start", int'(startup_ticks), 3);
    // R5 schedule with varying arrivals; R6 arithmetic
    for (int i = 0; i < 12; i++) cyc(i % 3 != 0, 1, 18 + i, 0, "R6");
    // R12: sizes offered while no removal is due
    for (int i = 0; i < 3; i++) cyc(0, !size_ready, 999, 0, "R12");
    // R7: oversized picture at the next tick
    for (int i = 0; i < 5; i++) cyc(1, 1, 500, 0, "R7");
    cyc(0, 0, 0, 1, "R11");
    // R8: fill beyond capacity
    for (int i = 0; i < 16; i++) cyc(1, 1, 1, 0, "R8");
    // R10: stalled removal, then late size
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, "R10");
    cyc(0, 1, 5, 0, "R10");
    // R11: clear while a stall keeps raising the flag, then a clean clear
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, "R11");
    cyc(0, 1, 1, 1, "R11");
    cyc(0, 0, 0, 0, "R11");

    do_reset(7, 20, 60, 3);
    for (int i = 0; i < 14; i++) cyc(i % 2 == 0, 1, 9, 0, "R4");
    chk("R4", "startup second config", int'(startup_ticks), 5);
    for (int i = 0; i < 10; i++) cyc(1, 1, 4 + 3 * i, 0, "R6");
    cyc(0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, "R2");
    finish_run();
  end
endmodule